// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block drives the timing side of a parallel RGB panel. It produces horizontal sync, vertical sync, data enable and the column and row of the current active pixel. It also emits a one-cycle interrupt pulse when vertical blanking begins. A small write port loads five 32-bit configuration words. These set the sync widths, the two pairs of porches, the active size, the sync polarities and the panel colour format. The counters advance only on cycles where the pixel strobe is high, so one fast system clock can serve any pixel rate.

Configuration writes land in a shadow bank. The working copy that drives the counters takes the shadow contents only at the edge where the frame wraps, so a write in the middle of a frame cannot tear the picture. The incoming 24-bit pixel is passed to the output with the low bits of each channel cleared to match the selected panel depth. The output pixel is zero outside the active area.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset the working configuration is all zero and the position is the first sync cycle of the first sync line. So hsync=1, vsync=1, de=0, x=0, y=0, vblank_irq=0, out_mode=0.
- R2: Word address 0 holds (horizontal sync length − 1) in bits 15:0 and (vertical sync length − 1, in lines) in bits 31:16.
- R3: Word address 1 holds (vertical front porch − 1) in bits 15:0 and the vertical back porch as a plain line count in bits 31:16. A count of zero gives no back-porch lines.
- R4: Word address 2 holds (horizontal front porch − 1) in bits 15:0 and (horizontal back porch − 1) in bits 31:16.
- R5: Word address 3 holds (active width − 1) in bits 15:0 and (active height − 1) in bits 31:16.
- R6: Each line runs sync, back porch, active, front porch in strobe counts, and each frame runs the same four phases in lines.
- R7: Position and all timing outputs hold while pix_stb is low.
- R8: In word address 4, bit 0 set makes hsync active-low and bit 1 set makes vsync active-low. Otherwise both are active-high.
- R9: de is high only when both axes are in their active phase. Then x and y give the zero-based active column and row. x is 0 outside horizontal active and y is 0 outside vertical active.
- R10: vblank_irq is high for exactly one clock, in the cycle after the strobe that moves from the last active line into the first front-porch line.
- R11: Writes go to a shadow bank. The working copy, including out_mode and polarity, takes the shadow only at the strobe that wraps from the last cycle of the frame to the first.
- R12: Bits 9:8 of word address 4 select the panel format: 0 = 4:4:4, 1 = 5:6:5, 2 = 6:6:6, 3 = 8:8:8 bits kept per red (23:16), green (15:8) and blue (7:0). pix_out keeps the top bits of each channel, clears the rest, and is all zero when de is low.
- R13: Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_stb | input | 1 | Pixel-clock enable strobe |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Configuration word address |
| wr_data | input | 32 | Configuration write data |
| pix_in | input | 24 | Incoming pixel, red high, blue low |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Data enable |
| x | output | 16 | Active column |
| y | output | 16 | Active row |
| vblank_irq | output | 1 | Start-of-vertical-blank pulse |
| pix_out | output | 24 | Pixel masked to the panel format |
| out_mode | output | 2 | Working panel-format code |

## Verification
The bench builds the block with its default eight-bit channels, so all four format masks are reachable, including the uneven green width. All timing fields are kept to a handful of cycles. Frames are then only tens to a few hundred strobes long. Many configuration swaps therefore happen at frame wraps within a short run, and mid-frame writes, writes to unused addresses, and a zero vertical back porch all occur often. Gaps in the random strobe exercise the hold behaviour next to every phase boundary.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
    localparam int WORD_W  = 32;
    localparam int FIELD_W = WORD_W / 2;
    localparam int REG_AW  = 3;

    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BACK  = 2'd1,
        PH_ACT   = 2'd2,
        PH_FRONT = 2'd3
    } lcdt_phase_e;

    typedef struct packed {
        logic [FIELD_W-1:0] hsw_m1;
        logic [FIELD_W-1:0] vsw_m1;
        logic [FIELD_W-1:0] vfp_m1;
        logic [FIELD_W-1:0] vbp_raw;
        logic [FIELD_W-1:0] hfp_m1;
        logic [FIELD_W-1:0] hbp_m1;
        logic [FIELD_W-1:0] wid_m1;
        logic [FIELD_W-1:0] hgt_m1;
        logic               hs_low;
        logic               vs_low;
        logic [1:0]         mode;
    } lcdt_cfg_t;

    // bits kept at the top of a colour channel for a format code
    function automatic int lcdt_keep_bits(input logic [1:0] mode, input int ch);
        case (mode)
            2'd0:    return 4;
            2'd1:    return (ch == 1) ? 6 : 5;
            2'd2:    return 6;
            default: return 8;
        endcase
    endfunction
endpackage

// File: rtl/lcdt_cfg_bank.sv
module lcdt_cfg_bank
    import lcdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              load,
    output lcdt_cfg_t         work
);
    typedef struct packed {
        lcdt_cfg_t shadow;
        lcdt_cfg_t work;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.work = st_q.shadow;
        end
        if (wr_en) begin
            case (wr_addr)
                3'd0: begin
                    st_d.shadow.hsw_m1 = wr_data[FIELD_W-1:0];
                    st_d.shadow.vsw_m1 = wr_data[WORD_W-1:FIELD_W];
                end
                3'd1: begin
                    st_d.shadow.vfp_m1  = wr_data[FIELD_W-1:0];
                    st_d.shadow.vbp_raw = wr_data[WORD_W-1:FIELD_W];
                end
                3'd2: begin
                    st_d.shadow.hfp_m1 = wr_data[FIELD_W-1:0];
                    st_d.shadow.hbp_m1 = wr_data[WORD_W-1:FIELD_W];
                end
                3'd3: begin
                    st_d.shadow.wid_m1 = wr_data[FIELD_W-1:0];
                    st_d.shadow.hgt_m1 = wr_data[WORD_W-1:FIELD_W];
                end
                3'd4: begin
                    st_d.shadow.hs_low = wr_data[0];
                    st_d.shadow.vs_low = wr_data[1];
                    st_d.shadow.mode   = wr_data[9:8];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign work = st_q.work;

    AST_WORK_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(st_q.work)) else $error("working config changed mid-frame"); // R11
endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis
    import lcdt_pkg::*;
#(
    parameter int LEN_W = FIELD_W + 1,
    localparam int CNT_W = LEN_W - 1
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [LEN_W-1:0] len_sync,
    input  logic [LEN_W-1:0] len_back,
    input  logic [LEN_W-1:0] len_act,
    input  logic [LEN_W-1:0] len_front,
    output lcdt_phase_e      phase,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    typedef struct packed {
        lcdt_phase_e      ph;
        logic [CNT_W-1:0] cnt;
    } axis_t;

    axis_t            st_d, st_q;
    logic [LEN_W-1:0] cur_len;

    always_comb begin
        case (st_q.ph)
            PH_SYNC:  cur_len = len_sync;
            PH_BACK:  cur_len = len_back;
            PH_ACT:   cur_len = len_act;
            default:  cur_len = len_front;
        endcase
        last = ({1'b0, st_q.cnt} == cur_len - 1'b1);

        st_d = st_q;
        if (step) begin
            if (last) begin
                st_d.cnt = '0;
                case (st_q.ph)
                    PH_SYNC:  st_d.ph = (len_back == '0) ? PH_ACT : PH_BACK;
                    PH_BACK:  st_d.ph = PH_ACT;
                    PH_ACT:   st_d.ph = PH_FRONT;
                    default:  st_d.ph = PH_SYNC;
                endcase
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_SYNC, cnt: '0};
        else        st_q <= st_d;
    end

    assign phase = st_q.ph;
    assign cnt   = st_q.cnt;

    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(st_q)) else $error("axis moved without a step"); // R7
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, st_q.cnt} < cur_len)) else $error("count beyond phase length"); // R6
    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph != $past(st_q.ph)) |->
            ((2'(st_q.ph) == 2'(2'($past(st_q.ph)) + 2'd1)) ||
             ($past(st_q.ph) == PH_SYNC && st_q.ph == PH_ACT)))
        else $error("phase out of order"); // R6
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
    import lcdt_pkg::*;
#(
    parameter int CH_W = 8,
    localparam int PIX_W = 3 * CH_W,
    localparam int LEN_W = FIELD_W + 1
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_stb,
    input  logic               wr_en,
    input  logic [REG_AW-1:0]  wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic [PIX_W-1:0]   pix_in,
    output logic               hsync,
    output logic               vsync,
    output logic               de,
    output logic [FIELD_W-1:0] x,
    output logic [FIELD_W-1:0] y,
    output logic               vblank_irq,
    output logic [PIX_W-1:0]   pix_out,
    output logic [1:0]         out_mode
);
    typedef struct packed {
        logic irq;
    } top_t;

    lcdt_cfg_t          cfg;
    lcdt_phase_e        h_ph, v_ph;
    logic [FIELD_W-1:0] h_cnt, v_cnt;
    logic               h_last, v_last;
    logic               line_wrap, frame_wrap;
    top_t               st_d, st_q;

    assign line_wrap  = pix_stb && h_last && (h_ph == PH_FRONT);
    assign frame_wrap = line_wrap && v_last && (v_ph == PH_FRONT);

    lcdt_cfg_bank i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (frame_wrap),
        .work    (cfg)
    );

    lcdt_axis #(.LEN_W(LEN_W)) i_haxis (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (pix_stb),
        .len_sync  ({1'b0, cfg.hsw_m1} + 1'b1),
        .len_back  ({1'b0, cfg.hbp_m1} + 1'b1),
        .len_act   ({1'b0, cfg.wid_m1} + 1'b1),
        .len_front ({1'b0, cfg.hfp_m1} + 1'b1),
        .phase     (h_ph),
        .cnt       (h_cnt),
        .last      (h_last)
    );

    lcdt_axis #(.LEN_W(LEN_W)) i_vaxis (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (line_wrap),
        .len_sync  ({1'b0, cfg.vsw_m1} + 1'b1),
        .len_back  ({1'b0, cfg.vbp_raw}),
        .len_act   ({1'b0, cfg.hgt_m1} + 1'b1),
        .len_front ({1'b0, cfg.vfp_m1} + 1'b1),
        .phase     (v_ph),
        .cnt       (v_cnt),
        .last      (v_last)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = line_wrap && v_last && (v_ph == PH_ACT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hsync      = (h_ph == PH_SYNC) ^ cfg.hs_low;
    assign vsync      = (v_ph == PH_SYNC) ^ cfg.vs_low;
    assign de         = (h_ph == PH_ACT) && (v_ph == PH_ACT);
    assign x          = (h_ph == PH_ACT) ? h_cnt : '0;
    assign y          = (v_ph == PH_ACT) ? v_cnt : '0;
    assign vblank_irq = st_q.irq;
    assign out_mode   = cfg.mode;

    for (genvar c = 0; c < 3; c++) begin : g_chan
        logic [CH_W-1:0] keep_mask;
        always_comb begin
            for (int b = 0; b < CH_W; b++) begin
                keep_mask[b] = (b >= CH_W - lcdt_keep_bits(cfg.mode, c));
            end
        end
        assign pix_out[c*CH_W +: CH_W] = de ? (pix_in[c*CH_W +: CH_W] & keep_mask) : '0;
    end

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_irq |=> !vblank_irq) else $error("vblank pulse too long"); // R10
    AST_IRQ_AT_FRONT: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_irq |-> (v_ph == PH_FRONT)) else $error("vblank pulse outside front porch"); // R10
endmodule

// File: tb/test_lcd_timing_gen.sv
module test_lcd_timing_gen;
    localparam int CH_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_stb = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [23:0] pix_in = '0;
    logic        hsync, vsync, de, vblank_irq;
    logic [15:0] x, y;
    logic [23:0] pix_out;
    logic [1:0]  out_mode;

    lcd_timing_gen #(.CH_W(CH_W)) i_lcd_timing_gen (
        .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pix_in(pix_in),
        .hsync(hsync), .vsync(vsync), .de(de), .x(x), .y(y),
        .vblank_irq(vblank_irq), .pix_out(pix_out), .out_mode(out_mode)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [31:0] sh [5];
    logic [31:0] wk [5];
    int hp = 0;
    int vp = 0;
    bit irq_exp = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int lo(input logic [31:0] w); return int'(w[15:0]); endfunction
    function automatic int hi(input logic [31:0] w); return int'(w[31:16]); endfunction

    function automatic logic [23:0] exp_pix(input logic [23:0] p, input logic [1:0] m, input bit en);
        logic [23:0] r;
        int keep;
        r = '0;
        for (int c = 0; c < 3; c++) begin
            case (m)
                2'd0: keep = 4;
                2'd1: keep = (c == 1) ? 6 : 5;
                2'd2: keep = 6;
                default: keep = 8;
            endcase
            for (int b = 0; b < 8; b++)
                if (b >= 8 - keep) r[c*8+b] = p[c*8+b];
        end
        return en ? r : 24'h0;
    endfunction

    // expected outputs from the model position and working words
    task automatic compare_all();
        int hs, hb, aw, hfp, vs, vb, ah;
        bit hact, vact;
        hs = lo(wk[0]) + 1;  vs = hi(wk[0]) + 1;          // R2
        vb = hi(wk[1]);                                   // R3 raw back porch
        hb = hi(wk[2]) + 1;  hfp = lo(wk[2]) + 1;         // R4
        aw = lo(wk[3]) + 1;  ah = hi(wk[3]) + 1;          // R5
        hact = (hp >= hs + hb) && (hp < hs + hb + aw);
        vact = (vp >= vs + vb) && (vp < vs + vb + ah);
        chk("R2 R6 R8 hsync", 32'(hsync), 32'((hp < hs) ^ wk[4][0]));
        chk("R3 R6 R8 vsync", 32'(vsync), 32'((vp < vs) ^ wk[4][1]));
        chk("R6 R9 de", 32'(de), 32'(hact && vact));
        chk("R4 R9 x", 32'(x), hact ? 32'(hp - hs - hb) : 32'd0);
        chk("R5 R9 y", 32'(y), vact ? 32'(vp - vs - vb) : 32'd0);
        chk("R10 vblank_irq", 32'(vblank_irq), 32'(irq_exp));
        chk("R11 R13 out_mode", 32'(out_mode), 32'(wk[4][9:8]));
        chk("R12 pix_out", 32'(pix_out), 32'(exp_pix(pix_in, wk[4][9:8], hact && vact)));
        if (hfp < 0) chk("R4 front", 0, 1);
    endtask

    task automatic step_model();
        int htot, vtot, first_front;
        htot = (lo(wk[0]) + 1) + (hi(wk[2]) + 1) + (lo(wk[3]) + 1) + (lo(wk[2]) + 1);
        first_front = (hi(wk[0]) + 1) + hi(wk[1]) + (hi(wk[3]) + 1);
        vtot = first_front + lo(wk[1]) + 1;
        irq_exp = 0;
        if (pix_stb) begin // R7: model moves only on a strobe
            hp++;
            if (hp == htot) begin
                hp = 0;
                vp++;
                if (vp == first_front) irq_exp = 1;
                if (vp == vtot) begin
                    vp = 0;
                    for (int i = 0; i < 5; i++) wk[i] = sh[i]; // R11
                end
            end
        end
        if (wr_en && wr_addr < 3'd5) sh[wr_addr] = wr_data; // R13: 5..7 dropped
    endtask

    // called at a falling edge: check, drive, advance model, reach next falling edge
    task automatic cycle(input bit stb, input bit we, input logic [2:0] a, input logic [31:0] d);
        compare_all();
        pix_stb = stb; wr_en = we; wr_addr = a; wr_data = d;
        pix_in = 24'($urandom);
        step_model();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] rnd_word(input logic [2:0] a);
        case (a)
            3'd0: return {16'($urandom_range(0, 3)), 16'($urandom_range(0, 3))};
            3'd1: return {16'($urandom_range(0, 2)), 16'($urandom_range(0, 3))};
            3'd2: return {16'($urandom_range(0, 3)), 16'($urandom_range(0, 3))};
            3'd3: return {16'($urandom_range(0, 5)), 16'($urandom_range(0, 5))};
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic h0, v0, d0;
        logic [15:0] x0, y0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 5; i++) begin sh[i] = '0; wk[i] = '0; end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 hsync", 32'(hsync), 32'd1);
        chk("R1 vsync", 32'(vsync), 32'd1);
        chk("R1 de", 32'(de), 32'd0);
        chk("R1 xy", {x, y}, 32'd0);
        chk("R1 irq", 32'(vblank_irq), 32'd0);
        chk("R1 mode", 32'(out_mode), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed: zero vertical back porch, both syncs active-low, 5:6:5
        cycle(0, 1, 3'd0, {16'd1, 16'd1});
        cycle(0, 1, 3'd1, {16'd0, 16'd1});
        cycle(0, 1, 3'd2, {16'd1, 16'd0});
        cycle(0, 1, 3'd3, {16'd2, 16'd3});
        cycle(0, 1, 3'd4, 32'h0000_0103);
        for (int i = 0; i < 400; i++) cycle(1, 0, 3'd0, 32'd0);

        // R7: hold strobe low and observe a frozen position
        h0 = hsync; v0 = vsync; d0 = de; x0 = x; y0 = y;
        for (int i = 0; i < 6; i++) cycle(0, 0, 3'd0, 32'd0);
        chk("R7 hold", {13'd0, h0, v0, d0, x0}, {13'd0, hsync, vsync, de, x});
        chk("R7 hold y", 32'(y0), 32'(y));

        // R13: junk to unused addresses, then run
        cycle(0, 1, 3'd5, 32'hFFFF_FFFF);
        cycle(0, 1, 3'd6, 32'hFFFF_FFFF);
        cycle(0, 1, 3'd7, 32'hFFFF_FFFF);
        for (int i = 0; i < 300; i++) cycle(1, 0, 3'd0, 32'd0);

        // random strobe gaps and mid-frame writes
        for (int i = 0; i < 15000; i++) begin
            logic [2:0] a;
            bit we;
            a = 3'($urandom_range(0, 7));
            we = ($urandom_range(0, 40) == 0);
            cycle($urandom_range(0, 3) != 0, we, a, rnd_word(a));
        end
        compare_all();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule